// File: doc/BRIEF.md
# Continuous Multi-Profile Address Sequencer

This block produces read addresses for a waveform memory by sweeping through a chain of address ranges called profiles. Each profile has a start address, an end address and a step-rate value. The sequencer plays the first profile's range at that profile's own pace. It flags the arrival at the range's last address, holds there for one more interval, then moves on to the next profile. After the last profile in the chain it goes back to profile 0, and it keeps looping until it is reconfigured.

A control field chooses how many profiles take part in the loop, always counted from profile 0. That field is captured only by a registered update strobe. The same strobe also restarts the sweep at profile 0. The profile parameter registers are inputs to the block. The memory array and the datapath that uses its data are outside the block.

Top module: `prof_chain_addr_seq`

## Requirements
- R1: After reset and before the first update strobe, `addr_o` is 0, `prof_o` is 0 and `eos_o` is 0.
- R2: One cycle after `upd_i` is sampled high, `addr_o` equals profile 0's start address, `prof_o` is 0 and `loop_last_i` has been captured. `loop_last_i` is captured only at that point.
- R3: Within a profile whose rate field holds r, each address stays on `addr_o` for r+1 cycles, and then the address increases by exactly one.
- R4: `eos_o` is high in the first cycle that `addr_o` shows the active profile's end address and in the cycle after it. Outside those cycles it is low.
- R5: Once the end address has been held for its full r+1 cycles, the next cycle shows the following profile's start address and index, and that profile's rate value governs its pace.
- R6: With `loop_last_i` = c, profiles 0 through c play in ascending order, and profile 0 follows profile c. With c = 0, profile 0 repeats on its own.
- R7: A profile whose end address is below its start address behaves as a one-address range that holds its start address.
- R8: Changing `loop_last_i` without an update strobe has no effect. Changing the registers of profiles outside the loop also has no effect.
- R9: An update strobe during a running sweep restarts at profile 0's start address and drops any end flag still pending from the earlier sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | Registered update strobe; captures the loop size and restarts the sweep |
| loop_last_i | input | IDX_W | Index of the last profile in the loop |
| prof_start_i | input | NPROF*ADDR_W | Start address of each profile, profile k at bits [k*ADDR_W +: ADDR_W] |
| prof_end_i | input | NPROF*ADDR_W | End address of each profile, same packing as the start addresses |
| prof_rate_i | input | NPROF*RATE_W | Step-rate value of each profile; one step every value+1 cycles |
| addr_o | output | ADDR_W | Current waveform memory address |
| prof_o | output | IDX_W | Index of the active profile |
| eos_o | output | 1 | End-of-sweep flag, two cycles wide |

## Verification
The bench builds the block with four profiles, 6-bit addresses and 4-bit rate values. Under this configuration a full loop lasts only a few dozen cycles, so the bench can compare every cycle of several complete loops against an expected trace. It computes that trace arithmetically from each profile's range length and rate. The small configuration also brings the extreme cases into reach: rate 0, an inverted range, a range at the top address, a one-profile loop, and a one-address profile at rate 0, where the end flag never drops.

// File: rtl/prof_seq_pkg.sv
package prof_seq_pkg;
  localparam int FLAG_CYCLES = 2;

  // effective last address of a range; an inverted range collapses to its start
  function automatic int range_last(input int first, input int last);
    return (last < first) ? first : last;
  endfunction

  // profile index that follows cur in a loop ending at top
  function automatic int wrap_next(input int cur, input int top);
    return (cur >= top) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/prof_seq_pick.sv
module prof_seq_pick #(
  parameter int NPROF  = 8,
  parameter int ADDR_W = 10,
  parameter int RATE_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [NPROF*ADDR_W-1:0] starts_i,
  input  logic [NPROF*ADDR_W-1:0] ends_i,
  input  logic [NPROF*RATE_W-1:0] rates_i,
  output logic [ADDR_W-1:0]       start_o,
  output logic [ADDR_W-1:0]       last_o,
  output logic [RATE_W-1:0]       rate_o
);
  import prof_seq_pkg::*;

  logic [ADDR_W-1:0] s_a [NPROF];
  logic [ADDR_W-1:0] l_a [NPROF];
  logic [RATE_W-1:0] r_a [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_unpack
    assign s_a[g] = starts_i[g*ADDR_W +: ADDR_W];
    assign r_a[g] = rates_i[g*RATE_W +: RATE_W];
    assign l_a[g] = ADDR_W'(range_last(int'(starts_i[g*ADDR_W +: ADDR_W]),
                                       int'(ends_i[g*ADDR_W +: ADDR_W])));
  end

  assign start_o = s_a[idx_i];
  assign last_o  = l_a[idx_i];
  assign rate_o  = r_a[idx_i];
endmodule

// File: rtl/prof_seq_timer.sv
module prof_seq_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [RATE_W-1:0] load_val_i,
  output logic              expire_o
);
  logic [RATE_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // R3: the counter never skips a value while it runs
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/prof_seq_flag.sv
module prof_seq_flag #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  assign flag_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (fire_i)       left_q <= CW'(LEN);
    else if (clr_i)        left_q <= '0;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  // R4: a fresh flag lasts into the next cycle
  a_r4_flag_two: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> flag_o ##1 (flag_o || $past(clr_i) || $past(fire_i)));
endmodule

// File: rtl/prof_chain_addr_seq.sv
module prof_chain_addr_seq #(
  parameter int NPROF  = 8,
  parameter int ADDR_W = 10,
  parameter int RATE_W = 16,
  localparam int IDX_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_i,
  input  logic [IDX_W-1:0]        loop_last_i,
  input  logic [NPROF*ADDR_W-1:0] prof_start_i,
  input  logic [NPROF*ADDR_W-1:0] prof_end_i,
  input  logic [NPROF*RATE_W-1:0] prof_rate_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [IDX_W-1:0]        prof_o,
  output logic                    eos_o
);
  import prof_seq_pkg::*;

  logic              run_q;
  logic [IDX_W-1:0]  last_q, prof_q, nxt_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] cur_start, cur_end, nxt_start, nxt_end, p0_start, p0_end;
  logic [RATE_W-1:0] cur_rate, nxt_rate, p0_rate, reload_val;
  logic              expire_w, switch_w, step_w, arrive_w;

  assign nxt_idx = IDX_W'(wrap_next(int'(prof_q), int'(last_q)));

  prof_seq_pick #(.NPROF(NPROF), .ADDR_W(ADDR_W), .RATE_W(RATE_W), .IDX_W(IDX_W)) cur_i (
    .idx_i(prof_q), .starts_i(prof_start_i), .ends_i(prof_end_i), .rates_i(prof_rate_i),
    .start_o(cur_start), .last_o(cur_end), .rate_o(cur_rate));
  prof_seq_pick #(.NPROF(NPROF), .ADDR_W(ADDR_W), .RATE_W(RATE_W), .IDX_W(IDX_W)) nxt_i (
    .idx_i(nxt_idx), .starts_i(prof_start_i), .ends_i(prof_end_i), .rates_i(prof_rate_i),
    .start_o(nxt_start), .last_o(nxt_end), .rate_o(nxt_rate));
  prof_seq_pick #(.NPROF(NPROF), .ADDR_W(ADDR_W), .RATE_W(RATE_W), .IDX_W(IDX_W)) p0_i (
    .idx_i('0), .starts_i(prof_start_i), .ends_i(prof_end_i), .rates_i(prof_rate_i),
    .start_o(p0_start), .last_o(p0_end), .rate_o(p0_rate));

  // named events
  assign switch_w = expire_w && !upd_i && (addr_q == cur_end);
  assign step_w   = expire_w && !upd_i && (addr_q != cur_end);
  assign arrive_w = upd_i    ? (p0_start == p0_end) :
                    switch_w ? (nxt_start == nxt_end) :
                    step_w   ? (addr_q + 1'b1 == cur_end) : 1'b0;
  assign reload_val = upd_i ? p0_rate : (switch_w ? nxt_rate : cur_rate);

  prof_seq_timer #(.RATE_W(RATE_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .load_i(upd_i || expire_w),
    .load_val_i(reload_val), .expire_o(expire_w));

  prof_seq_flag #(.LEN(FLAG_CYCLES)) flag_i (
    .clk(clk), .rst_n(rst_n), .fire_i(arrive_w), .clr_i(upd_i), .flag_o(eos_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      last_q <= '0;
      prof_q <= '0;
      addr_q <= '0;
    end else if (upd_i) begin
      run_q  <= 1'b1;
      last_q <= loop_last_i;
      prof_q <= '0;
      addr_q <= p0_start;
    end else if (switch_w) begin
      prof_q <= nxt_idx;
      addr_q <= nxt_start;
    end else if (step_w) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign prof_o = prof_q;

  // R1: idle until the first strobe
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (addr_q == '0 && prof_q == '0 && !eos_o));
  // R2: strobe loads profile 0
  a_r2_update_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (prof_q == '0 && addr_q == $past(p0_start)));
  // R3: a step moves by exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !upd_i && expire_w && addr_q != cur_end) |=> (addr_q == $past(addr_q) + 1'b1));
  // R5: nothing moves between expiries
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !upd_i && !expire_w) |=> ($stable(addr_q) && $stable(prof_q)));
  // R6: the index stays inside the loop
  a_r6_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (prof_q <= last_q));
endmodule

// File: tb/prof_chain_addr_seq_tb.sv
module prof_chain_addr_seq_tb_top;
  localparam int NP = 4, AW = 6, RW = 4, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0;
  logic [IW-1:0] ctl = '0;
  logic [AW-1:0] st [NP];
  logic [AW-1:0] en [NP];
  logic [RW-1:0] rt [NP];
  logic [NP*AW-1:0] st_f, en_f;
  logic [NP*RW-1:0] rt_f;
  logic [AW-1:0] addr;
  logic [IW-1:0] prof;
  logic eos;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      st_f[k*AW +: AW] = st[k];
      en_f[k*AW +: AW] = en[k];
      rt_f[k*RW +: RW] = rt[k];
    end
  end

  prof_chain_addr_seq #(.NPROF(NP), .ADDR_W(AW), .RATE_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .loop_last_i(ctl),
    .prof_start_i(st_f), .prof_end_i(en_f), .prof_rate_i(rt_f),
    .addr_o(addr), .prof_o(prof), .eos_o(eos));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected state t cycles after an update, from range lengths and dwell times
  task automatic model(input int t, input int last, output int a, output int p, output bit arr);
    int per = 0, tt, len, dw, idx;
    a = 0; p = 0; arr = 0;
    for (int q = 0; q <= last; q++) begin
      len = ((en[q] < st[q]) ? int'(st[q]) : int'(en[q])) - int'(st[q]) + 1;
      per += len * (int'(rt[q]) + 1);
    end
    tt = t % per;
    for (int q = 0; q <= last; q++) begin
      len = ((en[q] < st[q]) ? int'(st[q]) : int'(en[q])) - int'(st[q]) + 1;
      dw = int'(rt[q]) + 1;
      if (tt < len * dw) begin
        idx = tt / dw;
        a = int'(st[q]) + idx; p = q;
        arr = (idx == len - 1) && (tt % dw == 0);
        return;
      end
      tt -= len * dw;
    end
  endtask

  // sample at negedges t0 .. t0+n-1 after an update
  task automatic trace(input int t0, input int n, input int last, input string tag);
    int a, p, ap, pp; bit arr, arrp, e;
    for (int t = t0; t < t0 + n; t++) begin
      model(t, last, a, p, arr);
      arrp = 0;
      if (t >= 1) model(t - 1, last, ap, pp, arrp);
      e = arr || arrp;
      chk(int'(addr) == a, {tag, " addr"}, int'(addr), a);
      chk(int'(prof) == p, {tag, " prof"}, int'(prof), p);
      chk(eos == e, {tag, " R4 eos"}, int'(eos), int'(e));
      @(negedge clk);
    end
  endtask

  task automatic update(input int c);
    ctl = IW'(c); upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic set_p(input int k, input int s, input int e, input int r);
    st[k] = AW'(s); en[k] = AW'(e); rt[k] = RW'(r);
  endtask

  initial begin
    for (int k = 0; k < NP; k++) set_p(k, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs before any strobe
    chk(addr == '0, "R1 addr", int'(addr), 0);
    chk(prof == '0, "R1 prof", int'(prof), 0);
    chk(eos == 1'b0, "R1 eos", int'(eos), 0);

    // two-profile loop
    set_p(0, 3, 6, 2); set_p(1, 10, 12, 1);
    update(1);
    trace(0, 40, 1, "R2 R3 R5 R6 two-profile");
    // R8: unused profiles and the control field alone change nothing
    set_p(2, 30, 33, 0); set_p(3, 50, 51, 5); ctl = 2'd3;
    trace(40, 40, 1, "R8 no strobe");

    // four profiles: rate 0, inverted range (R7), top address
    set_p(0, 0, 2, 0); set_p(1, 20, 5, 3); set_p(2, 40, 43, 1); set_p(3, 63, 63, 2);
    update(3);
    trace(0, 30, 3, "R6 R7 four-profile");
    // R9: restart mid-sweep with a two-profile loop
    set_p(0, 3, 6, 2); set_p(1, 10, 12, 1);
    update(1);
    trace(0, 30, 1, "R9 restart");

    // one-profile loop
    set_p(0, 7, 9, 1);
    update(0);
    trace(0, 20, 0, "R6 single loop");
    // one-address profile at rate 0: flag stays high
    set_p(0, 5, 5, 0);
    update(0);
    trace(0, 8, 0, "R4 R7 one-address");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule